// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by an integer N that is chosen by an 8-bit word and may change every output period. It sits in the feedback path of a fractional-N synthesizer. A modulator upstream updates the word once per output period, so the loop sees an average ratio between integers. Inside, a dual-modulus prescaler counts by 5 or by 4. A program counter sets how many prescaler periods make one output period, and a swallow counter sets how many of those periods use the longer modulus. The ratio is N = 4·M + A.

The word is sampled only on the clock edge that closes a period. Changes to the word at any other time cannot disturb the period in progress. While the synchronous reset is high, the block reloads from the word on every edge. After release, several dividers on the same clock therefore produce their first pulse on the same edge and stay in step.

Top module: `pulse_swallow_div`

## Requirements
- R1: For a word D from 8 to 255, the divider divides by N = D + 4, giving every ratio from 12 to 259.
- R2: Word 4 selects division by 8, and word 5 selects division by 9.
- R3: Words 0, 1, 2, 3, 6 and 7 have no ratio of their own, and each one divides by 12.
- R4: div_out is high for exactly one clock per output period, and successive rising edges of div_out are N clocks apart.
- R5: The word is sampled only on the clock edge at which div_out goes high, and on edges while rst is high. A value present on any other edge has no effect on any period.
- R6: rst is synchronous and active high. After any edge that samples rst high, div_out is low, and the counters hold the ratio from the word on that edge.
- R7: Take the first edge that samples rst low as edge 1. div_out then goes high after edge N, where N comes from the word on the last reset edge.
- R8: Each period's length follows the word sampled at the pulse that opened it, so consecutive periods may all differ.
- R9: Two dividers that are released from reset on the same edge, with the same word, pulse on the same edges whatever each one did before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset and phase alignment |
| div_word | input | 8 | Ratio word, N = word + 4 |
| div_out | output | 1 | One-clock pulse per divided period |

## Verification
The bench covers both ends of the main range (12 and 259), the two short special ratios, and every invalid word. A design with an off-by-one in the modulus or program counter would show periods one clock long or short. A design that mishandled the swallow count would fail only for some residues of N modulo 4. The bench scrambles the word throughout each period and restores it just before the closing edge, so a design that samples the word late or continuously would give the wrong period length. It also releases two dividers with different histories on a shared edge, which exposes a design whose reset leaves residual prescaler state as a constant phase offset.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int WORD_W    = 8;
    localparam int OFFSET    = 4;
    localparam int PRE_LOW   = 4;
    localparam int SWAL_W    = $clog2(PRE_LOW);
    localparam int N_W       = WORD_W + 1;
    localparam int M_W       = N_W - SWAL_W;
    localparam int PRE_CNT_W = $clog2(PRE_LOW + 1);
    localparam int MIN_N     = 12;
    localparam int SHORT_A   = 8;
    localparam int SHORT_B   = 9;

    typedef struct packed {
        logic [M_W-1:0]    m;
        logic [SWAL_W-1:0] a;
    } ratio_t;

    function automatic logic [N_W-1:0] word_to_n(input logic [WORD_W-1:0] w,
                                                  input logic allow_short);
        logic [N_W-1:0] n;
        n = {1'b0, w} + N_W'(OFFSET);
        if (n >= N_W'(MIN_N))
            return n;
        if (allow_short && (n == N_W'(SHORT_A) || n == N_W'(SHORT_B)))
            return n;
        return N_W'(MIN_N);
    endfunction

    function automatic ratio_t split_n(input logic [N_W-1:0] n);
        ratio_t r;
        r.m = n[N_W-1:SWAL_W];
        r.a = n[SWAL_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/psd_word_decode.sv
module psd_word_decode
    import psd_pkg::*;
#(
    parameter bit ALLOW_SHORT = 1'b1
) (
    input  logic [WORD_W-1:0] word,
    output ratio_t            cfg
);
    logic [N_W-1:0] n;

    generate
        if (ALLOW_SHORT) begin : g_short
            always_comb n = word_to_n(word, 1'b1);
        end else begin : g_main_only
            always_comb n = word_to_n(word, 1'b0);
        end
    endgenerate

    always_comb cfg = split_n(n);
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reload_five,
    output logic pre_end
);
    logic [PRE_CNT_W-1:0] cnt;

    always_comb pre_end = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || pre_end)
            cnt <= reload_five ? PRE_CNT_W'(PRE_LOW) : PRE_CNT_W'(PRE_LOW - 1);
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
    import psd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pre_end,
    input  ratio_t cfg,
    output logic   reload_five,
    output logic   period_end
);
    logic [M_W-1:0]    m_cnt;
    logic [SWAL_W-1:0] a_cnt;
    logic              load;

    always_comb begin
        period_end  = pre_end && (m_cnt == M_W'(1));
        load        = rst || period_end;
        reload_five = load ? (cfg.a != '0) : (a_cnt > SWAL_W'(1));
    end

    always_ff @(posedge clk) begin
        if (load) begin
            m_cnt <= cfg.m;
            a_cnt <= cfg.a;
        end else if (pre_end) begin
            m_cnt <= m_cnt - 1'b1;
            a_cnt <= (a_cnt != '0) ? a_cnt - 1'b1 : '0;
        end
    end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] div_word,
    output logic              div_out
);
    ratio_t cfg;
    logic   reload_five;
    logic   pre_end;
    logic   period_end;

    psd_word_decode #(.ALLOW_SHORT(1'b1)) u_dec (
        .word (div_word),
        .cfg  (cfg)
    );

    psd_prescaler u_pre (
        .clk         (clk),
        .rst         (rst),
        .reload_five (reload_five),
        .pre_end     (pre_end)
    );

    psd_swallow_ctrl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .pre_end     (pre_end),
        .cfg         (cfg),
        .reload_five (reload_five),
        .period_end  (period_end)
    );

    always_ff @(posedge clk) begin
        if (rst) div_out <= 1'b0;
        else     div_out <= period_end;
    end
endmodule

// File: rtl/psd_checker.sv
module psd_checker
    import psd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] div_word,
    input logic              div_out,
    input logic              period_end
);
    logic [N_W:0]   gap;
    logic [N_W-1:0] want;

    always_ff @(posedge clk) begin
        if (rst || period_end) begin
            gap  <= (N_W + 1)'(1);
            want <= word_to_n(div_word, 1'b1);
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !div_out); // R6

    AST_PERIOD_LENGTH: assert property (@(posedge clk) disable iff (rst)
        period_end |-> (gap == {1'b0, want})); // R1

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        !period_end |-> (gap < {1'b0, want})); // R5
endmodule

bind pulse_swallow_div psd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .div_word   (div_word),
    .div_out    (div_out),
    .period_end (period_end)
);

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_word = 8'd8;
    logic       div_out;
    logic       rst_b = 1'b1;
    logic [7:0] word_b = 8'd8;
    logic       out_b;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    pulse_swallow_div u_pulse_swallow_div (
        .clk(clk), .rst(rst), .div_word(div_word), .div_out(div_out));
    pulse_swallow_div u_pulse_swallow_div_b (
        .clk(clk), .rst(rst_b), .div_word(word_b), .div_out(out_b));

    function automatic int ref_n(input int w);
        if (w >= 8) return w + 4;
        if (w == 4) return 8;
        if (w == 5) return 9;
        return 12;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] w);
        @(negedge clk);
        rst = 1'b1;
        div_word = w;
        repeat (3) @(negedge clk);
        chk(div_out == 1'b0, "R6 low in reset", int'(div_out), 0);
        rst = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 600);
    endtask

    task automatic t_fixed(input logic [7:0] w, input string req);
        int n;
        do_reset(w);
        measure(n);
        chk(n == ref_n(w), "R7 first pulse", n, ref_n(w));
        @(negedge clk);
        chk(div_out == 1'b0, "R4 pulse width", int'(div_out), 0);
        measure(n);
        chk(n == ref_n(w) - 1, req, n + 1, ref_n(w));
        measure(n);
        chk(n == ref_n(w), req, n, ref_n(w));
    endtask

    task automatic t_sequence();
        logic [7:0] seq [8] = '{8'd8, 8'd255, 8'd4, 8'd5, 8'd9, 8'd10, 8'd11, 8'd100};
        int n;
        do_reset(seq[0]);
        div_word = seq[1];
        for (int i = 0; i < 7; i++) begin
            measure(n);
            chk(n == ref_n(seq[i]), "R8 per-period ratio", n, ref_n(seq[i]));
            div_word = seq[i+2 > 7 ? 7 : i+2];
        end
    endtask

    task automatic t_noisy();
        int n;
        int e;
        do_reset(8'd20);
        for (int p = 0; p < 3; p++) begin
            e = (p == 0) ? 24 : ref_n(13 + 30 * p);
            n = 0;
            do begin
                div_word = (n + 1 >= e - 2) ? 8'(13 + 30 * (p + 1)) : 8'(n * 37 + 11);
                @(negedge clk);
                n++;
            end while (!div_out && n < 600);
            chk(n == e, "R5 mid-period word ignored", n, e);
        end
    endtask

    task automatic t_align();
        int miss = 0;
        int n;
        do_reset(8'd33);
        rst_b = 1'b0;
        word_b = 8'd50;
        repeat (27) @(negedge clk);
        rst = 1'b1; rst_b = 1'b1;
        div_word = 8'd6; word_b = 8'd6;
        repeat (2) @(negedge clk);
        chk(div_out == 1'b0 && out_b == 1'b0, "R6 mid-run reset", int'(div_out) + int'(out_b), 0);
        div_word = 8'd15; word_b = 8'd15;
        @(negedge clk);
        rst = 1'b0; rst_b = 1'b0;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (div_out != out_b) miss++;
            if (c == 18) n = int'(div_out);
        end
        chk(miss == 0, "R9 aligned pulses", miss, 0);
        chk(n == 1, "R7 first pulse after release", n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(div_out == 1'b0, "R6 reset state", int'(div_out), 0);
        t_fixed(8'd8,   "R1 min ratio 12");
        t_fixed(8'd255, "R1 max ratio 259");
        t_fixed(8'd77,  "R1 mid ratio");
        t_fixed(8'd4,   "R2 ratio 8");
        t_fixed(8'd5,   "R2 ratio 9");
        t_fixed(8'd0,   "R3 invalid word 0");
        t_fixed(8'd3,   "R3 invalid word 3");
        t_fixed(8'd6,   "R3 invalid word 6");
        t_fixed(8'd7,   "R3 invalid word 7");
        t_sequence();
        t_noisy();
        t_align();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule